// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block converts parallel words from a host into asynchronous serial frames on a single transmit line. The host offers a word with `in_valid`. The block takes it in the same cycle in which `in_ready` is high. It then sends a frame made of four parts: a low start bit, between five and nine data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. The line rests high between frames.

Every frame samples its framing and bit timing from static configuration inputs in the cycle in which the word is taken. Software can therefore change the settings between words without stopping the line. The bit period is a whole number of clock cycles, set by `cfg_div`. It is the clock frequency divided by the wanted baud rate. For example, a 9600 baud line from a 50 MHz clock uses 5208. While a frame is on the line, `busy` is high and `in_ready` is low.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset and between frames, `tx` is 1. In the clock cycle after a handshake (`in_valid` and `in_ready` both high at a rising edge), `tx` goes to 0 for one bit period as the start bit.
- R2: After the start bit come the data bits, bit 0 of `in_data` first. The number of data bits is `cfg_bits`. A value below 5 is treated as 5 and a value above 9 is treated as 9. Bits of `in_data` above that count never reach the line.
- R3: `cfg_par` selects the parity mode: 2'b00 and 2'b11 mean no parity, 2'b01 means even parity and 2'b10 means odd parity. With even parity, one bit follows the data so that the ones in the data plus this bit are even in number. With odd parity, that count is odd.
- R4: When parity is enabled and the data length works out to 9, exactly 8 data bits are sent, and `in_data[8]` has no effect on the line or on the parity bit.
- R5: The frame ends with the line high for one stop bit when `cfg_stop2` is 0, or for two stop bits when it is 1.
- R6: Every bit of a frame lasts exactly `cfg_div` clock cycles. A divisor of 0 is treated as 1.
- R7: The data and all configuration inputs are sampled at the handshake. Changes to them during the frame do not alter that frame.
- R8: `busy` is 1 and `in_ready` is 0 from the cycle after the handshake until the last stop bit has lasted its full period. In the cycle after that, `busy` is 0 and `in_ready` is 1, so a new word can be taken.
- R9: Synchronous active-high reset leaves `tx` at 1, `busy` at 0 and `in_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Host offers a word |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | DATA_W (9) | Word to send, bit 0 goes first |
| cfg_bits | input | BITS_W (4) | Data bit count, 5 to 9 after clamping |
| cfg_par | input | 2 | Parity mode: 00/11 none, 01 even, 10 odd |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| cfg_div | input | DIV_W (16) | Clock cycles per bit, 0 means 1 |
| tx | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame is on the line |

## Verification
A corrupt bit counter or shift register shows on `tx` as a wrong bit, an early return to idle, or a late one. The first such error appears at most one bit period after the fault. The bench detects it in that cycle, because it rebuilds the expected line level from its own frame model on every clock. A bad divisor reload moves every later bit edge, so it shows up one bit period later as a level mismatch. A handshake or end-of-frame error shows at once as a mismatch of `busy` and `in_ready` against the model. Each frame's configuration is scrambled right after the handshake, so any leak of the live inputs into a running frame also shows on the line.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic [1:0] {
    PAR_OFF  = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_OFF2 = 2'b11
  } par_mode_e;

  localparam int unsigned MIN_DATA_BITS = 5;
endpackage

// File: rtl/utx_baud_gen.sv
module utx_baud_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] period,
  input  logic             run,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] rld_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else if (load) begin
      cnt_q <= period - 1'b1;
      rld_q <= period - 1'b1;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= rld_q;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q <= rld_q)) else $error("counter above reload"); // R6
endmodule

// File: rtl/utx_parity.sv
module utx_parity #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned BITS_W = 4
) (
  input  logic [DATA_W-1:0] data,
  input  logic [BITS_W-1:0] nbits,
  input  logic              odd,
  output logic              par
);
  always_comb begin
    par = odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(nbits)) par = par ^ data[i];
    end
  end
endmodule

// File: rtl/utx_sequencer.sv
module utx_sequencer #(
  parameter int unsigned FRAME_W = 13,
  parameter int unsigned LEN_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LEN_W-1:0]   len,
  input  logic               tick,
  output logic               tx,
  output logic               active
);
  logic [FRAME_W-2:0] sh_q;
  logic [LEN_W-1:0]   left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx     <= 1'b1;
      active <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
    end else if (start) begin
      tx     <= frame[0];
      active <= 1'b1;
      sh_q   <= frame[FRAME_W-1:1];
      left_q <= len - 1'b1;
    end else if (active && tick) begin
      if (left_q == '0) begin
        tx     <= 1'b1;
        active <= 1'b0;
      end else begin
        tx     <= sh_q[0];
        sh_q   <= {1'b1, sh_q[FRAME_W-2:1]};
        left_q <= left_q - 1'b1;
      end
    end
  end

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (active && !tick) |=> $stable(tx)) else $error("bit changed mid period"); // R6
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import utx_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned DIV_W  = 16,
  localparam int unsigned BITS_W  = $clog2(DATA_W + 1),
  localparam int unsigned FRAME_W = DATA_W + 4,
  localparam int unsigned LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [BITS_W-1:0] cfg_bits,
  input  logic [1:0]        cfg_par,
  input  logic              cfg_stop2,
  input  logic [DIV_W-1:0]  cfg_div,
  output logic              tx,
  output logic              busy
);
  par_mode_e          mode;
  logic               par_en;
  logic               par_bit;
  logic [BITS_W-1:0]  bits_c;
  logic [DIV_W-1:0]   div_c;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;
  logic               accept;
  logic               tick;
  logic               active;

  assign mode   = par_mode_e'(cfg_par);
  assign par_en = (mode == PAR_EVEN) || (mode == PAR_ODD);
  assign div_c  = (cfg_div == '0) ? DIV_W'(1) : cfg_div;

  always_comb begin
    if (cfg_bits < BITS_W'(MIN_DATA_BITS))  bits_c = BITS_W'(MIN_DATA_BITS);
    else if (cfg_bits > BITS_W'(DATA_W))    bits_c = BITS_W'(DATA_W);
    else                                    bits_c = cfg_bits;
    if (par_en && bits_c == BITS_W'(DATA_W)) bits_c = BITS_W'(DATA_W - 1);
  end

  utx_parity #(.DATA_W(DATA_W), .BITS_W(BITS_W)) u_par (
    .data  (in_data),
    .nbits (bits_c),
    .odd   (mode == PAR_ODD),
    .par   (par_bit)
  );

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(bits_c)) frame[i+1] = in_data[i];
    end
    if (par_en) frame[int'(bits_c) + 1] = par_bit;
    len = LEN_W'(int'(bits_c) + 2 + (par_en ? 1 : 0) + (cfg_stop2 ? 1 : 0));
  end

  assign accept   = in_valid && in_ready;
  assign in_ready = !active;
  assign busy     = active;

  utx_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .period (div_c),
    .run    (active),
    .tick   (tick)
  );

  utx_sequencer #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (accept),
    .frame  (frame),
    .len    (len),
    .tick   (tick),
    .tx     (tx),
    .active (active)
  );

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && !tx)) else $error("no start bit"); // R1
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx) else $error("line low while idle"); // R1
  AST_END_ON_STOP: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (tx && $past(tx))) else $error("frame ended off a stop bit"); // R5
endmodule

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [8:0] in_data = '0;
  logic [3:0] cfg_bits = 4'd8;
  logic [1:0] cfg_par = 2'b00;
  logic       cfg_stop2 = 1'b0;
  logic [15:0] cfg_div = 16'd4;
  logic       tx;
  logic       busy;

  uart_frame_tx dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_bits(cfg_bits), .cfg_par(cfg_par),
    .cfg_stop2(cfg_stop2), .cfg_div(cfg_div), .tx(tx), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    nchk = 0;
  int    nfail = 0;
  bit    done = 0;
  string phase = "reset";

  // model state
  bit    hs = 0;
  bit    mact = 0;
  logic  mtx = 1'b1;
  string mtag = "R1";
  int    mcnt = 0;
  int    s_div = 1;
  logic [8:0] s_data;
  int    s_bits, s_pm;
  bit    s_s2;
  logic  bq[$];
  string tq[$];

  task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s [%s] t=%0t got=%b exp=%b", tag, phase, $time, act, exp);
    end
  endtask

  task automatic build_frame();
    int nb = s_bits;
    int ones = 0;
    bit pen = (s_pm == 1) || (s_pm == 2);
    bit clamp9;
    if (nb < 5) nb = 5;
    if (nb > 9) nb = 9;
    clamp9 = pen && nb == 9;
    if (clamp9) nb = 8;
    bq.delete(); tq.delete();
    for (int i = 0; i < nb; i++) begin
      bq.push_back(s_data[i]);
      tq.push_back(clamp9 ? "R4" : "R2");
      if (s_data[i]) ones++;
    end
    if (pen) begin
      bq.push_back((s_pm == 1) ? logic'(ones % 2) : logic'(1 - ones % 2));
      tq.push_back("R3");
    end
    bq.push_back(1'b1); tq.push_back("R5");
    if (s_s2) begin bq.push_back(1'b1); tq.push_back("R5"); end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      chk(tx === 1'b1, "R9", tx, 1'b1);
      chk(busy === 1'b0, "R9", busy, 1'b0);
      chk(in_ready === 1'b1, "R9", in_ready, 1'b1);
      mact = 0; mtx = 1'b1; hs = 0;
    end else begin
      if (hs) begin
        build_frame();
        mact = 1; mtx = 1'b0; mtag = "R1"; mcnt = s_div - 1;
      end else if (mact) begin
        if (mcnt == 0) begin
          if (bq.size() == 0) begin
            mact = 0; mtx = 1'b1; mtag = "R1";
          end else begin
            mtx = bq.pop_front(); mtag = tq.pop_front(); mcnt = s_div - 1;
          end
        end else mcnt--;
      end
      chk(tx === mtx, mtag, tx, mtx);
      chk(busy === mact, "R8", busy, mact);
      chk(in_ready === !mact, "R8", in_ready, !mact);
      hs = in_valid && !mact;
      if (hs) begin
        s_data = in_data; s_bits = int'(cfg_bits); s_pm = int'(cfg_par);
        s_s2 = cfg_stop2; s_div = (cfg_div == 0) ? 1 : int'(cfg_div);
      end
    end
  end

  task automatic send(input logic [8:0] d, input int nb, input int pm, input bit s2, input int dv);
    @(posedge clk); #1;
    in_data = d; cfg_bits = 4'(nb); cfg_par = 2'(pm); cfg_stop2 = s2; cfg_div = 16'(dv);
    in_valid = 1'b1;
    forever begin
      @(posedge clk);
      if (hs) break;
    end
    #1;
    in_valid = 1'b0;
    // R7: scramble everything the running frame must ignore
    in_data = ~d; cfg_bits = 4'(15 - nb); cfg_par = 2'(~pm); cfg_stop2 = ~s2; cfg_div = 16'(dv + 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    phase = "R2 R3 R5 R6 R7 sweep";
    for (int nb = 4; nb <= 10; nb++)
      for (int pm = 0; pm < 4; pm++)
        for (int s2 = 0; s2 < 2; s2++)
          send(9'h1A5 ^ 9'(nb * 37 + pm * 11 + s2 * 5), nb, pm, s2[0], 1 + (nb + pm + s2) % 5);
    phase = "R4 nine bits with parity";
    send(9'h100, 9, 1, 1'b0, 3);
    send(9'h1FF, 9, 2, 1'b1, 2);
    send(9'h0FF, 9, 0, 1'b0, 2);
    phase = "R6 divisor zero";
    send(9'h0A5, 8, 1, 1'b0, 0);
    send(9'h15A, 7, 2, 1'b1, 0);
    phase = "R8 back to back";
    for (int i = 0; i < 4; i++) send(9'(i * 91), 8, 0, 1'b0, 6);
    phase = "R6 long period";
    send(9'h133, 9, 0, 1'b1, 40);
    phase = "drain";
    repeat (700) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog [%s] got=1 exp=0", phase);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule